// File: doc/BRIEF.md
# Half-Cycle Windowed Peak Detector

This block watches one voltage sample stream and a small group of current sample streams. It tracks the largest absolute value seen on each side over a measurement window. The window length is a count of half line cycles. Upstream logic supplies signed samples with per-stream valid strobes and a one-cycle pulse at every half-cycle boundary. When the programmed number of boundaries has passed, the block publishes the window's voltage peak and current peak. It also records which current channel produced the current peak and raises one flag for voltage and one for current.

The current peak is taken only over the channels allowed by an enable mask. The published current word carries the magnitude in its low bits and a one-hot channel marker just above. Loading a new window length discards the window in progress and starts counting again. The running maxima also start from zero at the beginning of every window. Flags stay set until they are cleared through a dedicated clear port.

Top module: `halfcyc_peak_tracker`

## Requirements
- R1: A window closes on the clock edge that takes the Nth half-cycle pulse since the window began, where N is the stored length. Published outputs change only on that edge, and a new window starts from zero maxima and a zero count.
- R2: The voltage result is the largest absolute value among valid voltage samples in the window, including samples in the same cycle as the closing pulse. It sits in bits 23:0 with bits 31:24 zero.
- R3: A sample of -8388608 (24'h800000) counts as magnitude 24'h7FFFFF on every stream.
- R4: The current result in bits 23:0 is the largest absolute value among valid samples of enabled current channels in the window.
- R5: Bits 26:24 of the current result are a one-hot marker: bit 24+k means channel k set the peak. The marker is 0 when the current result is zero, and bits 31:27 are zero.
- R6: When several channels give the same peak in one cycle, the lowest index is reported. A later sample equal to the held peak does not replace the earlier one.
- R7: Bit k of the enable mask admits current channel k. Samples on a channel whose bit is 0 have no effect on the current result or marker.
- R8: An all-zero enable mask acts as if all three channels were enabled.
- R9: Both the voltage and current peak flags become 1 on the edge that closes a window.
- R10: Clear bit 0 clears the voltage flag and clear bit 1 clears the current flag. A window closing in the same cycle keeps the flag set.
- R11: A length write stores the new length, zeroes the count and discards the running maxima. A half-cycle pulse in the write cycle is ignored, and nothing is published in that cycle.
- R12: A stored length of 0 means no window ever closes.
- R13: After reset, outputs and flags are 0 and the stored length is the DEF_WIN parameter (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_valid | input | 1 | Voltage sample strobe |
| v_sample | input | 24 | Signed voltage sample |
| i_valid | input | 3 | Per-channel current sample strobes |
| i_sample | input | 72 | Signed current samples, channel k in bits 24k+23:24k |
| half_cycle | input | 1 | One-cycle pulse at each half-cycle boundary |
| win_len | input | 8 | Window length in half line cycles |
| win_len_wr | input | 1 | Loads win_len and restarts the measurement |
| ch_en | input | 3 | Current channel enable mask |
| stat_clr | input | 2 | Flag clear: bit 0 voltage, bit 1 current |
| v_peak_out | output | 32 | Published voltage peak |
| i_peak_out | output | 32 | Published current peak with channel marker |
| v_pk_flag | output | 1 | Voltage peak event flag |
| i_pk_flag | output | 1 | Current peak event flag |

## Verification
Directed patterns cover one case each:
- a negative sample beating a smaller positive one;
- equal magnitudes on two channels in one cycle, and equal magnitudes arriving in separate cycles;
- a large sample on a masked channel;
- the all-zero mask;
- the most negative code;
- a length write in the middle of a window, with a pulse in the same cycle;
- a zero length;
- a clear arriving together with a window close.

The tie cases separate strict from non-strict comparison and fix the channel ordering. The masked and restarted cases show whether discarded samples leak into a published result. A long pseudo-random stretch then varies the valid strobes, masks, clears and pulse spacing, and a behavioural model is compared with every output on every clock.

// File: rtl/pk_pkg.sv
package pk_pkg;
   function automatic logic [23:0] sat_abs24(input logic [23:0] s);
      logic [23:0] r;
      if (!s[23])
         r = s;
      else if (s == 24'h800000)
         r = 24'h7FFFFF;
      else
         r = -s;
      return r;
   endfunction
endpackage

// File: rtl/pk_magnitude.sv
module pk_magnitude #(
   parameter int W = 24
) (
   input  logic [W-1:0] smp,
   output logic [W-1:0] mag
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   always_comb begin
      if (!smp[W-1])
         mag = smp;
      else if (smp == MOST_NEG)
         mag = MOST_POS;
      else
         mag = -smp;
   end
endmodule

// File: rtl/pk_window_ctr.sv
module pk_window_ctr #(
   parameter int WIN_W   = 8,
   parameter int DEF_WIN = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             half_cycle,
   input  logic [WIN_W-1:0] win_len,
   input  logic             win_len_wr,
   output logic             win_end,
   output logic [WIN_W-1:0] len_q
);
   localparam logic [WIN_W-1:0] LEN_RST = WIN_W'(DEF_WIN);
   logic [WIN_W-1:0] cnt_q;

   assign win_end = half_cycle && !win_len_wr && (len_q != '0) && (cnt_q == len_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= LEN_RST;
         cnt_q <= '0;
      end else if (win_len_wr) begin
         len_q <= win_len;
         cnt_q <= '0;
      end else if (win_end) begin
         cnt_q <= '0;
      end else if (half_cycle && len_q != '0) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pk_cur_arbiter.sv
module pk_cur_arbiter #(
   parameter int W   = 24,
   parameter int NCH = 3
) (
   input  logic [NCH-1:0]        sel,
   input  logic [NCH-1:0][W-1:0] mags,
   output logic [W-1:0]          best_mag,
   output logic [NCH-1:0]        best_oh
);
   logic [NCH:0][W-1:0]   stg_mag;
   logic [NCH:0][NCH-1:0] stg_oh;

   assign stg_mag[0] = '0;
   assign stg_oh[0]  = '0;

   for (genvar k = 0; k < NCH; k++) begin : g_stage
      logic take;
      assign take = sel[k] && (mags[k] > stg_mag[k]);
      assign stg_mag[k+1] = take ? mags[k] : stg_mag[k];
      assign stg_oh[k+1]  = take ? NCH'(1) << k : stg_oh[k];
   end

   assign best_mag = stg_mag[NCH];
   assign best_oh  = stg_oh[NCH];
endmodule

// File: rtl/halfcyc_peak_tracker.sv
module halfcyc_peak_tracker #(
   parameter int SAMP_W  = 24,
   parameter int NCH     = 3,
   parameter int WIN_W   = 8,
   parameter int OUT_W   = 32,
   parameter int DEF_WIN = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  v_valid,
   input  logic [SAMP_W-1:0]     v_sample,
   input  logic [NCH-1:0]        i_valid,
   input  logic [NCH*SAMP_W-1:0] i_sample,
   input  logic                  half_cycle,
   input  logic [WIN_W-1:0]      win_len,
   input  logic                  win_len_wr,
   input  logic [NCH-1:0]        ch_en,
   input  logic [1:0]            stat_clr,
   output logic [OUT_W-1:0]      v_peak_out,
   output logic [OUT_W-1:0]      i_peak_out,
   output logic                  v_pk_flag,
   output logic                  i_pk_flag
);
   localparam int V_PAD = OUT_W - SAMP_W;
   localparam int I_PAD = OUT_W - SAMP_W - NCH;

   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (I_PAD < 1) begin : g_bad_outw
      $error("OUT_W must exceed SAMP_W + NCH");
   end
   if (DEF_WIN >= (1 << WIN_W)) begin : g_bad_def
      $error("DEF_WIN does not fit WIN_W");
   end

   logic             win_end;
   logic [WIN_W-1:0] len_q;

   pk_window_ctr #(.WIN_W(WIN_W), .DEF_WIN(DEF_WIN)) u_win (
      .clk(clk), .rst_n(rst_n), .half_cycle(half_cycle),
      .win_len(win_len), .win_len_wr(win_len_wr),
      .win_end(win_end), .len_q(len_q)
   );

   logic [SAMP_W-1:0]          v_mag;
   logic [NCH-1:0][SAMP_W-1:0] i_mag;

   pk_magnitude #(.W(SAMP_W)) u_vmag (.smp(v_sample), .mag(v_mag));

   for (genvar k = 0; k < NCH; k++) begin : g_imag
      pk_magnitude #(.W(SAMP_W)) u_imag (
         .smp(i_sample[k*SAMP_W +: SAMP_W]), .mag(i_mag[k])
      );
   end

   logic [NCH-1:0]    en_eff;
   logic [SAMP_W-1:0] arb_mag;
   logic [NCH-1:0]    arb_oh;

   assign en_eff = (ch_en == '0) ? '1 : ch_en;

   pk_cur_arbiter #(.W(SAMP_W), .NCH(NCH)) u_arb (
      .sel(i_valid & en_eff), .mags(i_mag),
      .best_mag(arb_mag), .best_oh(arb_oh)
   );

   logic [SAMP_W-1:0] v_run_q, i_run_q, v_cand, i_cand;
   logic [NCH-1:0]    i_oh_q, i_oh_cand;
   logic [SAMP_W-1:0] v_pub_q, i_pub_q;
   logic [NCH-1:0]    i_oh_pub_q;

   always_comb begin
      v_cand    = (v_valid && v_mag > v_run_q) ? v_mag : v_run_q;
      i_cand    = i_run_q;
      i_oh_cand = i_oh_q;
      if (arb_oh != '0 && arb_mag > i_run_q) begin
         i_cand    = arb_mag;
         i_oh_cand = arb_oh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_run_q    <= '0;
         i_run_q    <= '0;
         i_oh_q     <= '0;
         v_pub_q    <= '0;
         i_pub_q    <= '0;
         i_oh_pub_q <= '0;
      end else if (win_len_wr || win_end) begin
         v_run_q <= '0;
         i_run_q <= '0;
         i_oh_q  <= '0;
         if (win_end) begin
            v_pub_q    <= v_cand;
            i_pub_q    <= i_cand;
            i_oh_pub_q <= i_oh_cand;
         end
      end else begin
         v_run_q <= v_cand;
         i_run_q <= i_cand;
         i_oh_q  <= i_oh_cand;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_pk_flag <= 1'b0;
         i_pk_flag <= 1'b0;
      end else begin
         if (win_end)          v_pk_flag <= 1'b1;
         else if (stat_clr[0]) v_pk_flag <= 1'b0;
         if (win_end)          i_pk_flag <= 1'b1;
         else if (stat_clr[1]) i_pk_flag <= 1'b0;
      end
   end

   assign v_peak_out = {{V_PAD{1'b0}}, v_pub_q};
   assign i_peak_out = {{I_PAD{1'b0}}, i_oh_pub_q, i_pub_q};
endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
   parameter int SAMP_W = 24,
   parameter int NCH    = 3,
   parameter int WIN_W  = 8,
   parameter int OUT_W  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             win_end,
   input logic             win_len_wr,
   input logic [WIN_W-1:0] len_q,
   input logic [1:0]       stat_clr,
   input logic [OUT_W-1:0] v_peak_out,
   input logic [OUT_W-1:0] i_peak_out,
   input logic             v_pk_flag,
   input logic             i_pk_flag
);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> ($stable(v_peak_out) && $stable(i_peak_out)));

   p_mag_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      v_peak_out[OUT_W-1:SAMP_W-1] == '0);

   p_marker_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(i_peak_out[SAMP_W +: NCH]));

   p_marker_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (i_peak_out[SAMP_W-1:0] == '0) |-> (i_peak_out[SAMP_W +: NCH] == '0));

   p_flags_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (v_pk_flag && i_pk_flag));

   p_vclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr[0] && !win_end) |=> !v_pk_flag);

   p_iclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr[1] && !win_end) |=> !i_pk_flag);

   p_wr_no_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
      win_len_wr |-> !win_end);

   p_zero_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q == '0) |-> !win_end);
endmodule

bind halfcyc_peak_tracker pk_checker #(
   .SAMP_W(SAMP_W), .NCH(NCH), .WIN_W(WIN_W), .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .win_end(win_end), .win_len_wr(win_len_wr),
   .len_q(len_q), .stat_clr(stat_clr), .v_peak_out(v_peak_out),
   .i_peak_out(i_peak_out), .v_pk_flag(v_pk_flag), .i_pk_flag(i_pk_flag)
);

// File: tb/sim_halfcyc_peak_tracker.sv
module sim_halfcyc_peak_tracker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v_valid = 1'b0;
   logic [23:0] v_sample = '0;
   logic [2:0]  i_valid = '0;
   logic [71:0] i_sample = '0;
   logic        half_cycle = 1'b0;
   logic [7:0]  win_len = '0;
   logic        win_len_wr = 1'b0;
   logic [2:0]  ch_en = 3'b111;
   logic [1:0]  stat_clr = '0;
   logic [31:0] v_peak_out, i_peak_out;
   logic        v_pk_flag, i_pk_flag;

   always #(CLK_PERIOD/2) clk = ~clk;

   halfcyc_peak_tracker u0 (
      .clk(clk), .rst_n(rst_n), .v_valid(v_valid), .v_sample(v_sample),
      .i_valid(i_valid), .i_sample(i_sample), .half_cycle(half_cycle),
      .win_len(win_len), .win_len_wr(win_len_wr), .ch_en(ch_en),
      .stat_clr(stat_clr), .v_peak_out(v_peak_out), .i_peak_out(i_peak_out),
      .v_pk_flag(v_pk_flag), .i_pk_flag(i_pk_flag)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   string cur_req = "R13";

   // behavioural reference
   int m_len = 2, m_cnt = 0;
   int m_vrun = 0, m_irun = 0, m_iidx = -1;
   int m_vout = 0, m_iout = 0, m_iidxout = -1;
   bit m_fv = 0, m_fi = 0;

   function automatic int absval(input logic [23:0] x);
      int s;
      s = int'($signed(x));
      if (s < 0) s = -s;
      if (s > 8388607) s = 8388607;
      return s;
   endfunction

   function automatic logic [31:0] pack_i(input int mag, input int idx);
      logic [31:0] r;
      r = 32'(mag);
      if (idx >= 0) r = r | (32'd1 << (24 + idx));
      return r;
   endfunction

   always @(posedge clk) begin : model
      int vm, bi, bk, vc, ic, icx, m;
      bit closing;
      logic [2:0] en;
      if (!rst_n) begin
         m_len = 2; m_cnt = 0; m_vrun = 0; m_irun = 0; m_iidx = -1;
         m_vout = 0; m_iout = 0; m_iidxout = -1; m_fv = 0; m_fi = 0;
      end else begin
         en = (ch_en == 3'b000) ? 3'b111 : ch_en;
         vm = absval(v_sample);
         vc = (v_valid && vm > m_vrun) ? vm : m_vrun;
         bi = 0; bk = -1;
         for (int k = 0; k < 3; k++) begin
            if (en[k] && i_valid[k]) begin
               m = absval(i_sample[k*24 +: 24]);
               if (m > bi) begin bi = m; bk = k; end
            end
         end
         ic = m_irun; icx = m_iidx;
         if (bk >= 0 && bi > m_irun) begin ic = bi; icx = bk; end
         closing = 0;
         if (win_len_wr) begin
            m_len = int'(win_len); m_cnt = 0;
            m_vrun = 0; m_irun = 0; m_iidx = -1;
         end else begin
            closing = half_cycle && m_len != 0 && (m_cnt + 1 == m_len);
            if (closing) begin
               m_vout = vc; m_iout = ic; m_iidxout = icx;
               m_cnt = 0; m_vrun = 0; m_irun = 0; m_iidx = -1;
            end else begin
               if (half_cycle && m_len != 0) m_cnt = m_cnt + 1;
               m_vrun = vc; m_irun = ic; m_iidx = icx;
            end
         end
         if (closing) m_fv = 1; else if (stat_clr[0]) m_fv = 0;
         if (closing) m_fi = 1; else if (stat_clr[1]) m_fi = 0;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "v_peak_out", v_peak_out, 32'(m_vout));
         chk(cur_req, "i_peak_out", i_peak_out, pack_i(m_iout, m_iidxout));
         chk(cur_req, "v_pk_flag", 32'(v_pk_flag), 32'(m_fv));
         chk(cur_req, "i_pk_flag", 32'(i_pk_flag), 32'(m_fi));
      end
   end

   task automatic cyc();
      @(negedge clk);
      v_valid = 0; i_valid = '0; half_cycle = 0; win_len_wr = 0; stat_clr = '0;
   endtask

   task automatic set_i(input int k, input logic [23:0] s);
      i_sample[k*24 +: 24] = s;
      i_valid[k] = 1'b1;
   endtask

   task automatic write_len(input logic [7:0] n);
      win_len = n; win_len_wr = 1; cyc();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      int seed;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R13 reset state
      chk("R13", "reset v", v_peak_out, 32'd0);
      chk("R13", "reset i", i_peak_out, 32'd0);
      chk("R13", "reset flags", {30'd0, v_pk_flag, i_pk_flag}, 32'd0);

      // R13 default length 2, R2 negative beats smaller positive, R9 flags
      cur_req = "R2";
      v_valid = 1; v_sample = 24'd40; half_cycle = 1; cyc();
      v_valid = 1; v_sample = -24'sd77; half_cycle = 1; cyc();
      chk("R2", "v peak after default window", v_peak_out, 32'd77);
      chk("R9", "flags after close", {30'd0, v_pk_flag, i_pk_flag}, 32'd3);

      // R10 separate clears
      cur_req = "R10";
      stat_clr = 2'b01; cyc();
      chk("R10", "v flag cleared", {30'd0, v_pk_flag, i_pk_flag}, 32'd1);
      stat_clr = 2'b10; cyc();
      chk("R10", "i flag cleared", {30'd0, v_pk_flag, i_pk_flag}, 32'd0);

      // R6 same-cycle tie, lowest index
      cur_req = "R6";
      write_len(8'd1);
      set_i(1, -24'sd500); set_i(2, 24'd500); half_cycle = 1; cyc();
      chk("R6", "same-cycle tie", i_peak_out, 32'h0200_01F4);

      // R3 saturation on both sides
      cur_req = "R3";
      v_valid = 1; v_sample = 24'h800000; set_i(0, 24'h800000); half_cycle = 1; cyc();
      chk("R3", "v most negative", v_peak_out, 32'h007F_FFFF);
      chk("R3", "i most negative", i_peak_out, 32'h017F_FFFF);

      // R7 masked channel ignored
      cur_req = "R7";
      ch_en = 3'b110;
      set_i(0, 24'd1000); set_i(1, 24'd20); set_i(2, 24'd10); half_cycle = 1; cyc();
      chk("R7", "masked ch0", i_peak_out, 32'h0200_0014);

      // R8 zero mask
      cur_req = "R8";
      ch_en = 3'b000;
      set_i(0, 24'd1000); half_cycle = 1; cyc();
      chk("R8", "zero mask", i_peak_out, 32'h0100_03E8);
      ch_en = 3'b111;

      // R6 equal magnitude later in time keeps earlier channel
      cur_req = "R6";
      write_len(8'd2);
      set_i(2, 24'd300); half_cycle = 1; cyc();
      set_i(0, -24'sd300); half_cycle = 1; cyc();
      chk("R6", "later equal sample", i_peak_out, 32'h0400_012C);

      // R11 restart discards window, pulse in write cycle ignored
      cur_req = "R11";
      v_valid = 1; v_sample = 24'd900; cyc();
      win_len = 8'd2; win_len_wr = 1; half_cycle = 1; cyc();
      v_valid = 1; v_sample = 24'd5; half_cycle = 1; cyc();
      chk("R11", "no close after one pulse", v_peak_out, 32'd0);
      half_cycle = 1; cyc();
      chk("R11", "old sample discarded", v_peak_out, 32'd5);

      // R12 zero length never closes
      cur_req = "R12";
      stat_clr = 2'b11; write_len(8'd0);
      for (int n = 0; n < 6; n++) begin
         v_valid = 1; v_sample = 24'd4000; half_cycle = 1; cyc();
      end
      chk("R12", "no publish at zero length", v_peak_out, 32'd5);
      chk("R12", "flags stay low", {30'd0, v_pk_flag, i_pk_flag}, 32'd0);

      // R10 set wins over clear
      cur_req = "R10";
      write_len(8'd1);
      stat_clr = 2'b11; v_valid = 1; v_sample = 24'd9; half_cycle = 1; cyc();
      chk("R10", "set beats clear", {30'd0, v_pk_flag, i_pk_flag}, 32'd3);

      // R1/R2/R4 pseudo-random stretch, model compared every cycle
      cur_req = "R4";
      write_len(8'd3);
      seed = 32'h1234_5678;
      for (int n = 0; n < 3000; n++) begin
         seed = seed * 1103515245 + 12345;
         v_valid = seed[3];
         v_sample = 24'(seed >>> 5);
         seed = seed * 1103515245 + 12345;
         i_valid = 3'(seed[6:4]);
         i_sample[23:0] = 24'(seed >>> 7);
         seed = seed * 1103515245 + 12345;
         i_sample[47:24] = 24'(seed >>> 3);
         seed = seed * 1103515245 + 12345;
         i_sample[71:48] = 24'(seed >>> 9);
         if (n % 8 == 0) i_sample[71:48] = i_sample[23:0];
         half_cycle = (n % 5 == 4);
         stat_clr = (seed[12:10] == 3'b000) ? 2'(seed[14:13]) : 2'b00;
         if (n % 250 == 249) ch_en = 3'(seed[17:15]);
         if (n == 1500) begin win_len = 8'd7; win_len_wr = 1; cur_req = "R1"; end
         cyc();
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule